// File: doc/BRIEF.md
# Masked Event Interrupt Controller

This block gathers single-cycle event indications from port logic into a set of sticky flags and drives an active-low, open-drain interrupt request towards a host. A host-writable enable register decides which flags may raise the request. Every flag is recorded when its event rises, whether or not the event is enabled. A write that sets either of two dedicated bits in a separate clear register releases the request.

The request pin never changes while a bus transaction is in progress. Its value is frozen while the busy indication is high, and the value that is pending is applied at the first clock edge that finds the bus idle. The output `irq_pull_low` is the enable of the open-drain pull-down. A value of 1 pulls the shared request line low, and a value of 0 leaves it released (high impedance). The pad cell itself sits outside this block.

Top module: `evt_irq_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, all flags and all enables are cleared and `irq_pull_low` is 0 (released) after that edge.
- R2: A 0-to-1 transition of `evt_pulse[i]`, seen between two successive clock edges, sets flag i. The flag stays set until it is cleared. A level that is held high sets it only once.
- R3: When any flag is set while its enable bit is 1, and the bus is idle, `irq_pull_low` is 1 after the next clock edge. An event therefore reaches the pin two edges after it is sampled.
- R4: A write to address 0x01 loads the enable register, with data bit i enabling event i. A write to any other address leaves the enables unchanged. The enables reset to all zero.
- R5: A flag is recorded even while its event is disabled. If its enable bit is set later, the request asserts.
- R6: A write to address 0x1A with data bit 6 or bit 7 at 1 clears every flag. The other data bits of that register have no effect.
- R7: If a clear and a new rising event arrive at the same edge, the flag of that new event remains set.
- R8: While `bus_busy` is high at a clock edge, `irq_pull_low` keeps its value. At the first edge with `bus_busy` low, it takes the current pending state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| evt_pulse | input | NUM_EVT (8) | Event indications from port logic, one bit per source |
| wr_en | input | 1 | Register write strobe from the bus target |
| wr_addr | input | ADDR_W (8) | Register write address |
| wr_data | input | DATA_W (8) | Register write data |
| bus_busy | input | 1 | High while a bus transaction is in progress |
| irq_pull_low | output | 1 | 1 = pull the open-drain request line low; 0 = release it |

## Verification
A rising event is latched into its flag at the first edge. The pin follows at the second edge, because the output stage registers the pending state once more. A write to the clear register or the enable register changes the pin at the edge after the write. A busy edge adds latency only by holding the pin, so the value shows up at the first idle edge. The bench drives each vector just after a falling edge and reads the pin at the next falling edge. Each row's expected value is therefore the pending state that existed before that row's rising edge, or the held value on a busy row, and the table entries were worked out row by row on that basis.

// File: rtl/evt_irq_pkg.sv
// Package: shared constants for the masked event interrupt controller.
// Assumes: an 8-bit register address space on the bus target side.
package evt_irq_pkg;
    localparam int unsigned ADDR_W_DEF   = 8;
    localparam int unsigned DATA_W_DEF   = 8;
    localparam logic [7:0]  EN_ADDR_DEF  = 8'h01;
    localparam logic [7:0]  CLR_ADDR_DEF = 8'h1A;
    localparam int unsigned CLR_BIT_A    = 6;
    localparam int unsigned CLR_BIT_B    = 7;

    // One register write as seen from the bus target.
    typedef struct packed {
        logic                  en;
        logic [ADDR_W_DEF-1:0] addr;
        logic [DATA_W_DEF-1:0] data;
    } reg_wr_t;
endpackage

// File: rtl/evt_irq_regs.sv
// Module: evt_irq_regs
// Decodes register writes into the enable register and a one-cycle clear strobe.
// Assumes: the write strobe lasts one cycle per bus write; NUM_EVT <= DATA_W.
module evt_irq_regs #(
    parameter int unsigned NUM_EVT  = 8,
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned DATA_W   = 8,
    parameter logic [ADDR_W-1:0] EN_ADDR  = 8'h01,
    parameter logic [ADDR_W-1:0] CLR_ADDR = 8'h1A
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    output logic [NUM_EVT-1:0] en_q,
    output logic               clr_stb
);
    import evt_irq_pkg::*;

    logic en_hit;
    logic clr_hit;

    // Address decode for the two registers this block owns.
    always_comb begin
        en_hit  = wr_en && (wr_addr == EN_ADDR);
        clr_hit = wr_en && (wr_addr == CLR_ADDR);
        clr_stb = clr_hit && (wr_data[CLR_BIT_A] || wr_data[CLR_BIT_B]);
    end

    // Enable register: loads on a matching write, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (en_hit) begin
            en_q <= wr_data[NUM_EVT-1:0];
        end
    end

    // R4: a matching write lands in the enable register at the next edge.
    p_en_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == EN_ADDR) |=> (en_q == $past(wr_data[NUM_EVT-1:0])));
    // R4: writes elsewhere leave the enables alone.
    p_en_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_addr == EN_ADDR) |=> $stable(en_q));
endmodule

// File: rtl/evt_irq_flags.sv
// Module: evt_irq_flags
// Rising-edge detection on each event input and a sticky flag per event.
// Assumes: a clear strobe wipes all flags, but a rise at the same edge wins.
module evt_irq_flags #(
    parameter int unsigned NUM_EVT = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] evt_i,
    input  logic               clr_i,
    output logic [NUM_EVT-1:0] flags_q
);
    logic [NUM_EVT-1:0] evt_prev_q;
    logic [NUM_EVT-1:0] rise;

    for (genvar g = 0; g < NUM_EVT; g++) begin : g_evt
        // Rise detect for event g.
        always_comb rise[g] = evt_i[g] && !evt_prev_q[g];

        // Previous level and sticky flag for event g.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                evt_prev_q[g] <= 1'b0;
                flags_q[g]    <= 1'b0;
            end else begin
                evt_prev_q[g] <= evt_i[g];
                if (rise[g]) begin
                    flags_q[g] <= 1'b1;
                end else if (clr_i) begin
                    flags_q[g] <= 1'b0;
                end
            end
        end
    end

    // R2 / R5 / R7: every rise is recorded, masked or not, clear or not.
    p_rise_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rise != '0) |=> ((flags_q & $past(rise)) == $past(rise)));
    // R2: without a clear, flags never drop.
    p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> ((flags_q & $past(flags_q)) == $past(flags_q)));
    // R6: a clear leaves only the flags that rose at the same edge.
    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> ((flags_q & ~$past(rise)) == '0));
endmodule

// File: rtl/evt_irq_hold.sv
// Module: evt_irq_hold
// Output stage: registers the pending state, frozen while the bus is busy.
// Assumes: busy is synchronous to clk; output 1 means pull the line low.
module evt_irq_hold (
    input  logic clk,
    input  logic rst_n,
    input  logic pend_i,
    input  logic busy_i,
    output logic pull_q
);
    // Pin update only at edges that find the bus idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pull_q <= 1'b0;
        end else if (!busy_i) begin
            pull_q <= pend_i;
        end
    end

    // R8: no change across a busy edge.
    p_busy_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |=> (pull_q == $past(pull_q)));
endmodule

// File: rtl/evt_irq_ctrl.sv
// Module: evt_irq_ctrl (top)
// Sticky, maskable event flags driving an active-low open-drain request that
// changes only between bus transactions.
// Assumes: bus target supplies one-cycle write strobes and a busy level.
module evt_irq_ctrl #(
    parameter int unsigned NUM_EVT  = 8,
    parameter int unsigned ADDR_W   = evt_irq_pkg::ADDR_W_DEF,
    parameter int unsigned DATA_W   = evt_irq_pkg::DATA_W_DEF,
    parameter logic [ADDR_W-1:0] EN_ADDR  = evt_irq_pkg::EN_ADDR_DEF,
    parameter logic [ADDR_W-1:0] CLR_ADDR = evt_irq_pkg::CLR_ADDR_DEF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] evt_pulse,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic               bus_busy,
    output logic               irq_pull_low
);
    logic [NUM_EVT-1:0] en_q;
    logic [NUM_EVT-1:0] flags_q;
    logic               clr_stb;
    logic               pending;

    evt_irq_regs #(
        .NUM_EVT (NUM_EVT),
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .EN_ADDR (EN_ADDR),
        .CLR_ADDR(CLR_ADDR)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .en_q   (en_q),
        .clr_stb(clr_stb)
    );

    evt_irq_flags #(
        .NUM_EVT(NUM_EVT)
    ) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt_i  (evt_pulse),
        .clr_i  (clr_stb),
        .flags_q(flags_q)
    );

    // Any enabled flag makes the request pending.
    always_comb pending = |(flags_q & en_q);

    evt_irq_hold u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .pend_i(pending),
        .busy_i(bus_busy),
        .pull_q(irq_pull_low)
    );

    // R1: reset leaves flags, enables and the pin cleared.
    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> (flags_q == '0 && en_q == '0 && !irq_pull_low));
    // R3: an enabled flag on an idle edge drives the pin low next.
    p_enabled_asserts_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((flags_q & en_q) != '0 && !bus_busy) |=> irq_pull_low);
    // R6: with nothing enabled and set, an idle edge releases the pin.
    p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((flags_q & en_q) == '0 && !bus_busy) |=> !irq_pull_low);
endmodule

// File: tb/evt_irq_ctrl_tb.sv
// Bench for evt_irq_ctrl: a vector table, then directed reset tests.
module evt_irq_ctrl_tb;
    localparam int unsigned N = 8;

    typedef struct packed {
        logic [7:0] evt;
        logic       we;
        logic [7:0] addr;
        logic [7:0] data;
        logic       busy;
        logic       exp;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 33;
    // Each row: inputs for one cycle, expected pin after that cycle's edge.
    localparam vec_t TBL [NV] = '{
        '{8'h00, 1'b1, 8'h01, 8'h05, 1'b0, 1'b0, 4'd4},  // R4 enable 0,2
        '{8'h01, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 4'd3},  // R2 event 0 rises
        '{8'h00, 1'b0, 8'h00, 8'h00, 1'b0, 1'b1, 4'd3},  // R3 pin asserted
        '{8'h00, 1'b1, 8'h1A, 8'h40, 1'b0, 1'b1, 4'd6},  // R6 clear bit6
        '{8'h00, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 4'd6},  // R6 released
        '{8'h02, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 4'd5},  // R5 masked event 1
        '{8'h00, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 4'd5},  // R5 still quiet
        '{8'h00, 1'b1, 8'h01, 8'h02, 1'b0, 1'b0, 4'd5},  // R5 enable event 1
        '{8'h00, 1'b0, 8'h00, 8'h00, 1'b0, 1'b1, 4'd5},  // R5 latched flag shows
        '{8'h00, 1'b1, 8'h1A, 8'h3F, 1'b0, 1'b1, 4'd6},  // R6 low bits no effect
        '{8'h00, 1'b0, 8'h00, 8'h00, 1'b0, 1'b1, 4'd6},  // R6 still set
        '{8'h02, 1'b1, 8'h1A, 8'h80, 1'b0, 1'b1, 4'd7},  // R7 clear + rise
        '{8'h02, 1'b0, 8'h00, 8'h00, 1'b0, 1'b1, 4'd7},  // R7 rise survived
        '{8'h02, 1'b1, 8'h1A, 8'h80, 1'b0, 1'b1, 4'd2},  // R2 held level, clear
        '{8'h00, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 4'd2},  // R2 level did not re-set
        '{8'h02, 1'b0, 8'h00, 8'h00, 1'b1, 1'b0, 4'd8},  // R8 rise while busy
        '{8'h00, 1'b0, 8'h00, 8'h00, 1'b1, 1'b0, 4'd8},  // R8 held
        '{8'h00, 1'b0, 8'h00, 8'h00, 1'b1, 1'b0, 4'd8},  // R8 held
        '{8'h00, 1'b0, 8'h00, 8'h00, 1'b0, 1'b1, 4'd8},  // R8 first idle edge
        '{8'h00, 1'b1, 8'h1A, 8'hC0, 1'b1, 1'b1, 4'd8},  // R8 clear while busy
        '{8'h00, 1'b0, 8'h00, 8'h00, 1'b1, 1'b1, 4'd8},  // R8 held asserted
        '{8'h00, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 4'd8},  // R8 release applied
        '{8'h01, 1'b1, 8'h02, 8'hFF, 1'b0, 1'b0, 4'd4},  // R4 wrong address
        '{8'h00, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 4'd4},  // R4 enables unchanged
        '{8'h00, 1'b1, 8'h01, 8'h01, 1'b0, 1'b0, 4'd5},  // R5 enable event 0
        '{8'h00, 1'b0, 8'h00, 8'h00, 1'b0, 1'b1, 4'd5},  // R5 asserts
        '{8'h00, 1'b1, 8'h1A, 8'hC0, 1'b0, 1'b1, 4'd6},  // R6 both clear bits
        '{8'h00, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 4'd6},  // R6 released
        '{8'h00, 1'b1, 8'h01, 8'h80, 1'b0, 1'b0, 4'd4},  // R4 enable event 7
        '{8'h80, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 4'd3},  // R3 event 7 rises
        '{8'h00, 1'b0, 8'h00, 8'h00, 1'b0, 1'b1, 4'd3},  // R3 top bit asserts
        '{8'h00, 1'b1, 8'h1A, 8'h40, 1'b0, 1'b1, 4'd6},  // R6 clear
        '{8'h00, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 4'd6}   // R6 released
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] evt_pulse = '0;
    logic         wr_en = 1'b0;
    logic [7:0]   wr_addr = '0;
    logic [7:0]   wr_data = '0;
    logic         bus_busy = 1'b0;
    logic         irq_pull_low;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;  // 50 MHz

    evt_irq_ctrl u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .evt_pulse   (evt_pulse),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .bus_busy    (bus_busy),
        .irq_pull_low(irq_pull_low)
    );

    task automatic check(input logic exp, input string tag);
        n_chk++;
        if (irq_pull_low !== exp) begin
            n_bad++;
            $display("FAIL %s: irq_pull_low=%b expected %b", tag, irq_pull_low, exp);
        end
    endtask

    task automatic drive(input logic [7:0] e, input logic we, input logic [7:0] a,
                         input logic [7:0] d, input logic b);
        evt_pulse = e; wr_en = we; wr_addr = a; wr_data = d; bus_busy = b;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #1_000_000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check(1'b0, "R1 pin released in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check(1'b0, "R1 pin released after reset");

        for (int i = 0; i < NV; i++) begin
            drive(TBL[i].evt, TBL[i].we, TBL[i].addr, TBL[i].data, TBL[i].busy);
            @(negedge clk);
            check(TBL[i].exp, $sformatf("R%0d row %0d", TBL[i].req, i));
        end

        // R1: reset with a pending, enabled flag clears flags and enables.
        drive(8'h00, 1'b1, 8'h01, 8'h10, 1'b0);
        @(negedge clk);
        drive(8'h10, 1'b0, 8'h00, 8'h00, 1'b0);
        @(negedge clk);
        drive(8'h00, 1'b0, 8'h00, 8'h00, 1'b0);
        @(negedge clk);
        check(1'b1, "R3 event 4 asserted before reset");
        rst_n = 1'b0;
        @(negedge clk);
        check(1'b0, "R1 reset releases pin");
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(1'b0, "R1 flag cleared by reset");
        // R1: enables reset to zero, so a new event 4 stays silent.
        drive(8'h10, 1'b0, 8'h00, 8'h00, 1'b0);
        @(negedge clk);
        drive(8'h00, 1'b0, 8'h00, 8'h00, 1'b0);
        repeat (2) @(negedge clk);
        check(1'b0, "R1 enables cleared by reset");
        // R5: re-enable, latched flag now appears.
        drive(8'h00, 1'b1, 8'h01, 8'h10, 1'b0);
        @(negedge clk);
        drive(8'h00, 1'b0, 8'h00, 8'h00, 1'b0);
        @(negedge clk);
        check(1'b1, "R5 flag latched while disabled");
        // R8: clear during a long busy stretch, pin holds until idle.
        drive(8'h00, 1'b1, 8'h1A, 8'h80, 1'b1);
        @(negedge clk);
        drive(8'h00, 1'b0, 8'h00, 8'h00, 1'b1);
        repeat (5) @(negedge clk);
        check(1'b1, "R8 held through busy");
        drive(8'h00, 1'b0, 8'h00, 8'h00, 1'b0);
        @(negedge clk);
        check(1'b0, "R8 applied on first idle edge");

        finish_run();
    end
endmodule